// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit processor. Each cycle it receives the accumulator (or an index register, at the caller's choice) on one input, an operand byte on the other, and an operation code. The data results leave combinationally in the same cycle. These are the modified operand byte, the new accumulator value and a strobe saying whether the accumulator is to be written. The Negative, Overflow, Decimal, Zero and Carry flags are kept in a register inside the block. Every operation that uses a carry reads that register.

The flag register is updated on the rising clock edge when `exec_i` is high. A flag-load operation copies the flags from the operand, so the caller can also restore or set them. Besides the plain operations, the block performs the fused read-modify-combine forms in one pass. In these, the operand is shifted, rotated, incremented or decremented, and the modified byte is then folded into the accumulator. Decimal arithmetic is not implemented. The Decimal flag is only stored and reported.

Top module: `byte_alu_flags`

## Requirements
- R1: While `rst_n` is low, and after reset until the first executed operation, `flags_o` is zero. The layout of `flags_o` is C at bit 0, Z at bit 1, D at bit 2, V at bit 3 and N at bit 4.
- R2: Add (code 0) gives A + M + C. The 8-bit sum goes to `result_o` and `acc_o` with `acc_we_o`=1. C takes bit 8 of the sum. V is set when A and M have the same sign and the sum's sign differs from it. N and Z follow the sum.
- R3: Subtract (code 1) gives A − M − (1 − C). C is 1 when no borrow occurs. V is set when A and M differ in sign and the result's sign differs from A. N and Z follow the result, and the accumulator is written.
- R4: Compare (code 2) sets C when A ≥ M unsigned, and sets N and Z from the 8-bit A − M. It leaves V unchanged. `result_o` and `acc_o` equal A, and `acc_we_o`=0.
- R5: AND (3), OR (4) and XOR (5) write A op M to the accumulator and set N and Z from it. C and V keep their values.
- R6: Shift left (6) moves M bit 7 into C. Shift right (7) moves M bit 0 into C and always leaves N cleared. The shifted byte goes to `result_o`, `acc_we_o`=0, and N and Z follow the byte.
- R7: Rotate left (8) puts the old C into bit 0 and rotate right (9) puts it into bit 7. C takes the bit that is shifted out.
- R8: Increment (10) and decrement (11) return M ± 1 modulo 256 on `result_o` and set N and Z from it. C and V keep their values.
- R9: Bit test (12) copies M bit 7 to N and M bit 6 to V, and sets Z when A AND M is zero. C is kept, and `result_o`=`acc_o`=A with `acc_we_o`=0.
- R10: The fused forms are shift-left-then-OR (13), shift-right-then-XOR (14), rotate-left-then-AND (15) and rotate-right-then-add (16). Each returns the modified byte on `result_o` and writes A combined with that byte to the accumulator. N and Z follow the new accumulator. C comes from the shift, except in code 16, where the carry out of the rotate feeds the add and C and V come from that add.
- R11: Decrement-then-compare (17) returns M − 1 and compares A against it as in R4, without writing the accumulator. Increment-then-subtract (18) returns M + 1 and subtracts it from A as in R3, writing the accumulator.
- R12: Flag load (19) copies M bits 4..0 into `flags_o` using the R1 layout and returns M on `result_o`. A set D flag does not change the result of any arithmetic.
- R13: With `exec_i` low, `flags_o` holds its value whatever the other inputs do. Codes 20 to 31 return A and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Commit this cycle's flag update |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator or index register value (A) |
| opnd_i | input | 8 | Operand byte (M) |
| result_o | output | 8 | Modified operand or operation result |
| acc_o | output | 8 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 5 | Registered flags {N,V,D,Z,C} |

## Verification
The bench aims at the signed-overflow boundaries 0x7F+0x01 and 0x80−0x01. A design that derives V from the carry would miss both. A compare of equal values must set both Z and C, and an inverted borrow convention would clear C there. Shift right of 0xFF must clear N right after N was set, and rotate right with carry set must produce 0x80. Rotate-right-then-add must feed the rotated-out bit into the add rather than the old carry, and a design that used the stale flag would be off by one. Bit test against disjoint masks must give Z=1 while copying 1s into N and V, and idle cycles with changing inputs must leave the flags alone.

// File: rtl/bal_pkg.sv
package bal_pkg;

  localparam int FLAG_C    = 0;
  localparam int FLAG_Z    = 1;
  localparam int FLAG_D    = 2;
  localparam int FLAG_V    = 3;
  localparam int FLAG_N    = 4;
  localparam int FLAG_BITS = 5;
  localparam int OP_BITS   = 5;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_CMP  = 5'd2,  OP_AND  = 5'd3,
    OP_OR   = 5'd4,  OP_XOR  = 5'd5,  OP_SHL  = 5'd6,  OP_SHR  = 5'd7,
    OP_ROL  = 5'd8,  OP_ROR  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
    OP_BIT  = 5'd12, OP_SLOR = 5'd13, OP_SRXR = 5'd14, OP_RLAN = 5'd15,
    OP_RRAD = 5'd16, OP_DCMP = 5'd17, OP_ISUB = 5'd18, OP_LDF  = 5'd19
  } bal_op_e;

  typedef enum logic [2:0] {
    SK_PASS, SK_SHL, SK_SHR, SK_ROL, SK_ROR, SK_INC, SK_DEC
  } shift_k_e;

  typedef enum logic [1:0] { CI_FLAG, CI_ONE, CI_SHIFT } cin_k_e;
  typedef enum logic [1:0] { LK_AND, LK_OR, LK_XOR } logic_k_e;
  typedef enum logic [1:0] { AK_KEEP, AK_ADD, AK_LOGIC } acc_k_e;
  typedef enum logic [1:0] { RK_REG, RK_MOD, RK_ACC } res_k_e;
  typedef enum logic [2:0] { NZ_NONE, NZ_ACC, NZ_MOD, NZ_ADD, NZ_BIT } nz_k_e;
  typedef enum logic [1:0] { C_KEEP, C_ADD, C_SHIFT } c_k_e;
  typedef enum logic [1:0] { V_KEEP, V_ADD, V_BIT } v_k_e;

  typedef struct packed {
    shift_k_e shift_k;
    logic     add_inv;
    cin_k_e   cin_k;
    logic_k_e logic_k;
    acc_k_e   acc_k;
    res_k_e   res_k;
    nz_k_e    nz_k;
    c_k_e     c_k;
    v_k_e     v_k;
    logic     ld_flags;
  } bal_ctl_t;

  // Signed overflow of a + b: equal input signs, different result sign.
  function automatic logic sign_ovf(logic a_msb, logic b_msb, logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  function automatic bal_ctl_t bal_decode(logic [OP_BITS-1:0] op);
    bal_ctl_t c;
    c = '{shift_k: SK_PASS, add_inv: 1'b0, cin_k: CI_FLAG, logic_k: LK_AND,
          acc_k: AK_KEEP, res_k: RK_REG, nz_k: NZ_NONE, c_k: C_KEEP,
          v_k: V_KEEP, ld_flags: 1'b0};
    case (op)
      OP_ADD: begin
        c.acc_k = AK_ADD; c.res_k = RK_ACC; c.nz_k = NZ_ACC;
        c.c_k = C_ADD; c.v_k = V_ADD;
      end
      OP_SUB: begin
        c.add_inv = 1'b1; c.acc_k = AK_ADD; c.res_k = RK_ACC;
        c.nz_k = NZ_ACC; c.c_k = C_ADD; c.v_k = V_ADD;
      end
      OP_CMP: begin
        c.add_inv = 1'b1; c.cin_k = CI_ONE; c.nz_k = NZ_ADD; c.c_k = C_ADD;
      end
      OP_AND, OP_OR, OP_XOR: begin
        c.logic_k = (op == OP_AND) ? LK_AND : (op == OP_OR) ? LK_OR : LK_XOR;
        c.acc_k = AK_LOGIC; c.res_k = RK_ACC; c.nz_k = NZ_ACC;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        c.shift_k = (op == OP_SHL) ? SK_SHL : (op == OP_SHR) ? SK_SHR :
                    (op == OP_ROL) ? SK_ROL : SK_ROR;
        c.res_k = RK_MOD; c.nz_k = NZ_MOD; c.c_k = C_SHIFT;
      end
      OP_INC, OP_DEC: begin
        c.shift_k = (op == OP_INC) ? SK_INC : SK_DEC;
        c.res_k = RK_MOD; c.nz_k = NZ_MOD;
      end
      OP_BIT: begin
        c.logic_k = LK_AND; c.nz_k = NZ_BIT; c.v_k = V_BIT;
      end
      OP_SLOR, OP_SRXR, OP_RLAN: begin
        c.shift_k = (op == OP_SLOR) ? SK_SHL : (op == OP_SRXR) ? SK_SHR : SK_ROL;
        c.logic_k = (op == OP_SLOR) ? LK_OR : (op == OP_SRXR) ? LK_XOR : LK_AND;
        c.acc_k = AK_LOGIC; c.res_k = RK_MOD; c.nz_k = NZ_ACC; c.c_k = C_SHIFT;
      end
      OP_RRAD: begin
        c.shift_k = SK_ROR; c.cin_k = CI_SHIFT; c.acc_k = AK_ADD;
        c.res_k = RK_MOD; c.nz_k = NZ_ACC; c.c_k = C_ADD; c.v_k = V_ADD;
      end
      OP_DCMP: begin
        c.shift_k = SK_DEC; c.add_inv = 1'b1; c.cin_k = CI_ONE;
        c.res_k = RK_MOD; c.nz_k = NZ_ADD; c.c_k = C_ADD;
      end
      OP_ISUB: begin
        c.shift_k = SK_INC; c.add_inv = 1'b1; c.acc_k = AK_ADD;
        c.res_k = RK_MOD; c.nz_k = NZ_ACC; c.c_k = C_ADD; c.v_k = V_ADD;
      end
      OP_LDF: begin
        c.res_k = RK_MOD; c.ld_flags = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bal_shift_unit.sv
module bal_shift_unit
  import bal_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_k_e       kind_i,
  input  logic [W-1:0]   val_i,
  input  logic           cin_i,
  output logic [W-1:0]   val_o,
  output logic           cout_o
);
  always_comb begin
    val_o  = val_i;
    cout_o = cin_i;
    case (kind_i)
      SK_SHL: begin val_o = {val_i[W-2:0], 1'b0};  cout_o = val_i[W-1]; end
      SK_SHR: begin val_o = {1'b0, val_i[W-1:1]};  cout_o = val_i[0];   end
      SK_ROL: begin val_o = {val_i[W-2:0], cin_i}; cout_o = val_i[W-1]; end
      SK_ROR: begin val_o = {cin_i, val_i[W-1:1]}; cout_o = val_i[0];   end
      SK_INC: val_o = val_i + W'(1);
      SK_DEC: val_o = val_i - W'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/bal_adder.sv
module bal_adder
  import bal_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide;
  always_comb begin
    wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    ovf_o  = sign_ovf(a_i[W-1], b_i[W-1], wide[W-1]);
  end
endmodule

// File: rtl/bal_logic_unit.sv
module bal_logic_unit
  import bal_pkg::*;
#(
  parameter int W = 8
) (
  input  logic_k_e     kind_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (kind_i)
      LK_OR:   y_o = a_i | b_i;
      LK_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/bal_status_reg.sv
module bal_status_reg
  import bal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 ld_i,
  input  logic [FLAG_BITS-1:0] ld_val_i,
  input  logic                 wr_nz_i,
  input  logic                 n_i,
  input  logic                 z_i,
  input  logic                 wr_c_i,
  input  logic                 c_i,
  input  logic                 wr_v_i,
  input  logic                 v_i,
  output logic [FLAG_BITS-1:0] flags_o
);
  logic [FLAG_BITS-1:0] nxt;

  always_comb begin
    nxt = flags_o;
    if (ld_i) begin
      nxt = ld_val_i;
    end else begin
      if (wr_nz_i) begin nxt[FLAG_N] = n_i; nxt[FLAG_Z] = z_i; end
      if (wr_c_i)  nxt[FLAG_C] = c_i;
      if (wr_v_i)  nxt[FLAG_V] = v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_o <= '0;
    else if (en_i) flags_o <= nxt;
  end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import bal_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_i,
  input  logic [OP_BITS-1:0]   op_i,
  input  logic [W-1:0]         acc_i,
  input  logic [W-1:0]         opnd_i,
  output logic [W-1:0]         result_o,
  output logic [W-1:0]         acc_o,
  output logic                 acc_we_o,
  output logic [FLAG_BITS-1:0] flags_o
);
  bal_ctl_t   ctl;
  logic [W-1:0] mod_val, add_b, add_sum, logic_val, acc_new, nz_src;
  logic       shift_cout, add_cin, add_cout, add_ovf;
  logic       nz_wr, n_new, z_new, c_wr, c_new, v_wr, v_new;
  logic       carry_now;

  assign ctl       = bal_decode(op_i);
  assign carry_now = flags_o[FLAG_C];

  bal_shift_unit #(.W(W)) u_shift (
    .kind_i(ctl.shift_k), .val_i(opnd_i), .cin_i(carry_now),
    .val_o(mod_val), .cout_o(shift_cout)
  );

  assign add_b = ctl.add_inv ? ~mod_val : mod_val;
  always_comb begin
    case (ctl.cin_k)
      CI_ONE:   add_cin = 1'b1;
      CI_SHIFT: add_cin = shift_cout;
      default:  add_cin = carry_now;
    endcase
  end

  bal_adder #(.W(W)) u_add (
    .a_i(acc_i), .b_i(add_b), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  bal_logic_unit #(.W(W)) u_logic (
    .kind_i(ctl.logic_k), .a_i(acc_i), .b_i(mod_val), .y_o(logic_val)
  );

  always_comb begin
    case (ctl.acc_k)
      AK_ADD:   acc_new = add_sum;
      AK_LOGIC: acc_new = logic_val;
      default:  acc_new = acc_i;
    endcase
  end

  assign acc_o    = acc_new;
  assign acc_we_o = (ctl.acc_k != AK_KEEP);

  always_comb begin
    case (ctl.res_k)
      RK_MOD:  result_o = mod_val;
      RK_ACC:  result_o = acc_new;
      default: result_o = acc_i;
    endcase
  end

  always_comb begin
    case (ctl.nz_k)
      NZ_ACC:  nz_src = acc_new;
      NZ_MOD:  nz_src = mod_val;
      NZ_ADD:  nz_src = add_sum;
      default: nz_src = logic_val;
    endcase
    nz_wr = (ctl.nz_k != NZ_NONE);
    n_new = (ctl.nz_k == NZ_BIT) ? opnd_i[W-1] : nz_src[W-1];
    z_new = (nz_src == '0);
    c_wr  = (ctl.c_k != C_KEEP);
    c_new = (ctl.c_k == C_ADD) ? add_cout : shift_cout;
    v_wr  = (ctl.v_k != V_KEEP);
    v_new = (ctl.v_k == V_BIT) ? opnd_i[W-2] : add_ovf;
  end

  bal_status_reg u_flags (
    .clk(clk), .rst_n(rst_n), .en_i(exec_i),
    .ld_i(ctl.ld_flags), .ld_val_i(opnd_i[FLAG_BITS-1:0]),
    .wr_nz_i(nz_wr), .n_i(n_new), .z_i(z_new),
    .wr_c_i(c_wr), .c_i(c_new), .wr_v_i(v_wr), .v_i(v_new),
    .flags_o(flags_o)
  );
endmodule

// File: rtl/bal_flags_chk.sv
module bal_flags_chk
  import bal_pkg::*;
#(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 exec_i,
  input logic [OP_BITS-1:0]   op_i,
  input logic [W-1:0]         acc_i,
  input logic [W-1:0]         opnd_i,
  input logic [FLAG_BITS-1:0] flags_o,
  input logic                 add_cout
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flags_o == '0);

  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_ADD |=> flags_o[FLAG_C] == $past(add_cout));

  a_r4_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_CMP |=> flags_o[FLAG_C] == ($past(acc_i) >= $past(opnd_i)));

  a_r5_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=>
    flags_o[FLAG_C] == $past(flags_o[FLAG_C]) && flags_o[FLAG_V] == $past(flags_o[FLAG_V]));

  a_r6_shr_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_SHR |=> !flags_o[FLAG_N]);

  a_r9_bit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_BIT |=>
    flags_o[FLAG_N] == $past(opnd_i[W-1]) && flags_o[FLAG_V] == $past(opnd_i[W-2]));

  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(flags_o));
endmodule

bind byte_alu_flags bal_flags_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .acc_i(acc_i),
  .opnd_i(opnd_i), .flags_o(flags_o), .add_cout(add_cout)
);

// File: tb/byte_alu_flags_tb_top.sv
`timescale 1ns/1ps
module byte_alu_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [7:0] result_o, acc_o;
  logic       acc_we_o;
  logic [4:0] flags_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [4:0] mflags;

  always #5 clk = ~clk;

  byte_alu_flags dut_i (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .result_o(result_o), .acc_o(acc_o), .acc_we_o(acc_we_o),
    .flags_o(flags_o)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4";
      3, 4, 5: return "R5";  6, 7: return "R6";  8, 9: return "R7";
      10, 11: return "R8";  12: return "R9";  13, 14, 15, 16: return "R10";
      17, 18: return "R11";  19: return "R12";  default: return "R13";
    endcase
  endfunction

  // Independent reference model, flags packed as {N,V,D,Z,C}.
  task automatic model(input int op, input int a, input int m, input logic [4:0] f,
                       output int res, output int acc, output bit we,
                       output logic [4:0] nf);
    int c, s, t, c2, d;
    bit n, z, cc, v;
    c = f[0]; n = f[4]; z = f[1]; cc = f[0]; v = f[3];
    res = a; acc = a; we = 0; nf = f;
    case (op)
      0, 16: begin
        t = m; c2 = c;
        if (op == 16) begin t = (m >> 1) | (c << 7); c2 = m & 1; res = t; end
        s = a + t + c2; acc = s & 255; we = 1; if (op == 0) res = acc;
        cc = (s >> 8) & 1; v = ((~(a ^ t)) & (a ^ acc) & 128) != 0;
        n = acc[7]; z = (acc == 0);
      end
      1, 18: begin
        t = (op == 18) ? ((m + 1) & 255) : m;
        s = a - t - (1 - c); acc = s & 255; we = 1; res = (op == 18) ? t : acc;
        cc = (s >= 0); v = ((a ^ t) & (a ^ acc) & 128) != 0;
        n = acc[7]; z = (acc == 0);
      end
      2, 17: begin
        t = (op == 17) ? ((m + 255) & 255) : m;
        if (op == 17) res = t;
        d = (a - t) & 255; cc = (a >= t); n = d[7]; z = (d == 0);
      end
      3, 4, 5: begin
        acc = (op == 3) ? (a & m) : (op == 4) ? (a | m) : (a ^ m);
        res = acc; we = 1; n = acc[7]; z = (acc == 0);
      end
      6, 7, 8, 9: begin
        case (op)
          6: begin t = (m << 1) & 255; cc = m[7]; end
          7: begin t = m >> 1; cc = m[0]; end
          8: begin t = ((m << 1) | c) & 255; cc = m[7]; end
          default: begin t = (m >> 1) | (c << 7); cc = m[0]; end
        endcase
        res = t; n = t[7]; z = (t == 0);
      end
      10, 11: begin
        t = (op == 10) ? ((m + 1) & 255) : ((m + 255) & 255);
        res = t; n = t[7]; z = (t == 0);
      end
      12: begin n = m[7]; v = m[6]; z = ((a & m) == 0); end
      13, 14, 15: begin
        case (op)
          13: begin t = (m << 1) & 255; cc = m[7]; acc = a | t; end
          14: begin t = m >> 1; cc = m[0]; acc = a ^ t; end
          default: begin t = ((m << 1) | c) & 255; cc = m[7]; acc = a & t; end
        endcase
        res = t; we = 1; n = acc[7]; z = (acc == 0);
      end
      default: ;
    endcase
    if (op == 19) begin res = m; nf = m[4:0]; end
    else if (op < 19) nf = {n, v, f[2], z, cc};
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int a, input int m);
    int er, ea; bit ew; logic [4:0] ef;
    @(negedge clk);
    op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(m); exec_i = 1'b1;
    model(op, a, m, mflags, er, ea, ew, ef);
    #1;
    check(result_o == 8'(er), req_of(op), "result", result_o, er);
    check(acc_o == 8'(ea) && acc_we_o == ew, req_of(op), "acc/we",
          {acc_we_o, acc_o}, {ew, 8'(ea)});
    @(negedge clk);
    exec_i = 1'b0;
    check(flags_o == ef, req_of(op), "flags", flags_o, ef);
    mflags = ef;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      op_i = 5'($urandom_range(0, 31)); acc_i = 8'($urandom); opnd_i = 8'($urandom);
    end
    @(negedge clk);
    check(flags_o == mflags, "R13", "idle flags", flags_o, mflags);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    mflags = '0;
    repeat (3) @(negedge clk);
    check(flags_o == 5'd0, "R1", "reset flags", flags_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags_o == 5'd0, "R1", "flags after reset", flags_o, 0);
    // directed corners
    do_op(19, 0, 8'h00);
    do_op(0, 8'h7F, 8'h01);      // R2 signed overflow
    do_op(19, 0, 8'h01);         // C=1
    do_op(1, 8'h80, 8'h01);      // R3 overflow, no borrow
    do_op(2, 8'h42, 8'h42);      // R4 equal
    do_op(19, 0, 8'h10);         // N=1
    do_op(7, 8'h00, 8'hFF);      // R6 N cleared
    do_op(19, 0, 8'h01);
    do_op(9, 8'h00, 8'h00);      // R7 -> 0x80
    do_op(11, 8'h00, 8'h00);     // R8 wrap
    do_op(12, 8'h3F, 8'hC0);     // R9 disjoint
    do_op(19, 0, 8'h00);
    do_op(16, 8'h10, 8'h03);     // R10 rotated carry feeds add
    do_op(19, 0, 8'h01);
    do_op(18, 8'h05, 8'hFF);     // R11 inc wraps
    do_op(17, 8'h00, 8'h01);     // R11 dec to zero
    do_op(19, 0, 8'h04);         // R12 D set, C clear
    do_op(0, 8'h09, 8'h01);      // R12 binary result 0x0A
    do_op(25, 8'h33, 8'h44);     // R13 unused code
    idle(5);
    for (int k = 0; k < 600; k++) begin
      do_op($urandom_range(0, 21), $urandom_range(0, 255), $urandom_range(0, 255));
      if (k % 97 == 0) idle(3);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule